// File: doc/BRIEF.md
# Interrupt Active-State Register Bank

This block stores the active flag of every interrupt line handled by a small multi-core interrupt distributor. Software reaches it through a byte-wide request port that has two address windows. A write to the set window marks interrupts active. A write to the clear window marks them inactive. A read from either window returns the current flags. Each request carries the number of the CPU that issued it and a secure-access attribute. Every request gets a registered response one cycle later.

The low-numbered private interrupts have one flag per CPU, so each core sees and changes only its own copy. The shared interrupts have one flag that every core sees. When the security extension is turned on, a non-secure access cannot touch or observe group 0 interrupts. This filter applies bit by bit, so the other bits in the same byte are still handled normally. Each CPU's full view of the flags is also driven out, for use by the distributor's other logic.

Top module: `irqActiveBank`

## Requirements
- R1: After reset every active flag of every CPU reads 0, and `rspValid` and `rspErr` are 0.
- R2: Offsets 0x300 to 0x37F form the set window. Byte offset 0x300+k covers interrupts BASE_IRQ+8k+i, with i being the bit position 0..7 of the data byte. Writing 1 to a bit makes that interrupt active. Writing 0 leaves it unchanged.
- R3: Offsets 0x380 to 0x3FF form the clear window. It uses the same mapping, with 0x380 as its base. Writing 1 to a bit makes that interrupt inactive. Writing 0 leaves it unchanged.
- R4: An interrupt numbered below NUM_PRIV (32) has one flag per CPU. A write changes only the flag of the CPU named in `reqCpu`. A read returns that CPU's flag.
- R5: An interrupt at or above NUM_PRIV has a single flag. A write to it is seen by every CPU.
- R6: Suppose `secExtEn` is 1 and `reqSecure` is 0. A written bit whose interrupt has `grpBits` equal to 0 is skipped. The remaining bits of the same byte are applied.
- R7: Under the same condition, a read returns 0 for every bit whose interrupt has `grpBits` equal to 0.
- R8: Suppose the first interrupt of the addressed byte is NUM_IRQ or higher. The access is bad: `rspErr` is 1, `rspRdata` is 0, and no flag changes.
- R9: With REVISION other than 2, every access to either window is bad.
- R10: Each request with `reqValid` gets `rspValid` exactly one cycle later. `rspErr` is high only in that cycle and only for a bad access. Any offset outside 0x300 to 0x3FF is bad.
- R11: A read of a given byte returns the same eight flags through either window. Reads and idle cycles change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 12 | Byte offset within the distributor map |
| reqWdata | input | 8 | Write data, one bit per interrupt |
| reqCpu | input | CPU_W | Number of the requesting CPU |
| reqSecure | input | 1 | 1 = secure access |
| grpBits | input | NUM_IRQ | Group of each interrupt (0 = group 0) |
| secExtEn | input | 1 | Security extension enable |
| rspValid | output | 1 | Response for the request of the previous cycle |
| rspErr | output | 1 | Previous request was a bad access |
| rspRdata | output | 8 | Read data (0 for writes and bad accesses) |
| activeOut | output | NUM_CPU*NUM_IRQ | Bit c*NUM_IRQ+n is the flag of interrupt n as seen by CPU c |

## Verification
The bench builds the main instance with four CPUs, 96 interrupts and revision 2. With these values it can reach the last valid byte (interrupts 88 to 95), the first out-of-range byte in both windows, and the boundary between banked and shared flags at interrupts 31 and 32. A second instance uses two CPUs, 64 interrupts and revision 1, and receives the same traffic. On that instance every window access must come back as a bad access, and its state must stay at zero. The security filter is driven with a mix of group 0 and group 1 bits inside a single byte. This shows that the filter works per bit for both reads and writes.

// File: rtl/irqActivePkg.sv
package irqActivePkg;

  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] SET_BASE = 12'h300;
  localparam logic [ADDR_W-1:0] CLR_BASE = 12'h380;

  // Strobes from control to datapath
  typedef struct packed {
    logic       doSet;
    logic       doClear;
    logic       doRead;
    logic       doBad;
    logic [6:0] byteSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/irqActiveCtrl.sv
module irqActiveCtrl
  import irqActivePkg::*;
#(
  parameter int NUM_IRQ  = 96,
  parameter int BASE_IRQ = 0,
  parameter int REVISION = 2
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output ctrlStrobe_t       strobe
);

  localparam bit REV_OK = (REVISION == 2);

  logic inWindow;
  logic isClear;
  logic rangeBad;
  logic badAcc;
  logic [6:0] byteSel;

  assign inWindow = (reqAddr[ADDR_W-1:8] == SET_BASE[ADDR_W-1:8]);
  assign isClear  = reqAddr[7];
  assign byteSel  = reqAddr[6:0];
  assign rangeBad = ((32'(byteSel) * 32'd8) + 32'(BASE_IRQ)) >= 32'(NUM_IRQ);
  assign badAcc   = !inWindow || !REV_OK || rangeBad;

  always_comb begin
    strobe         = '0;
    strobe.byteSel = byteSel;
    if (reqValid) begin
      strobe.doBad   = badAcc;
      strobe.doSet   = !badAcc && reqWrite && !isClear;
      strobe.doClear = !badAcc && reqWrite && isClear;
      strobe.doRead  = !badAcc && !reqWrite;
    end
  end

endmodule

// File: rtl/irqActiveData.sv
module irqActiveData
  import irqActivePkg::*;
#(
  parameter int NUM_CPU  = 4,
  parameter int NUM_IRQ  = 96,
  parameter int NUM_PRIV = 32,
  parameter int BASE_IRQ = 0,
  parameter int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobe_t                strobe,
  input  logic [CPU_W-1:0]           reqCpu,
  input  logic                       reqSecure,
  input  logic [7:0]                 reqWdata,
  input  logic [NUM_IRQ-1:0]         grpBits,
  input  logic                       secExtEn,
  output logic                       rspValid,
  output logic                       rspErr,
  output logic [7:0]                 rspRdata,
  output logic [NUM_CPU*NUM_IRQ-1:0] activeOut
);

  localparam int VIEW_W = NUM_CPU * NUM_IRQ;

  logic [VIEW_W-1:0] viewFlat;
  logic [7:0]        rdNext;
  logic              nonSecGate;

  assign nonSecGate = secExtEn && !reqSecure;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : gIrq
    logic hitByte;
    logic wBit;
    logic apply;

    if (g >= BASE_IRQ) begin : gMapped
      assign hitByte = (32'(strobe.byteSel) == 32'((g - BASE_IRQ) / 8));
      assign wBit    = reqWdata[(g - BASE_IRQ) % 8];
    end else begin : gUnmapped
      assign hitByte = 1'b0;
      assign wBit    = 1'b0;
    end

    assign apply = hitByte && wBit && !(nonSecGate && !grpBits[g]);

    if (g < NUM_PRIV) begin : gBanked
      for (genvar c = 0; c < NUM_CPU; c++) begin : gCpu
        logic flag;
        always_ff @(posedge clk) begin
          if (!rstN) begin
            flag <= 1'b0;
          end else if (apply && (reqCpu == CPU_W'(c))) begin
            if (strobe.doSet)        flag <= 1'b1;
            else if (strobe.doClear) flag <= 1'b0;
          end
        end
        assign viewFlat[c*NUM_IRQ + g] = flag;
      end
    end else begin : gShared
      logic flag;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          flag <= 1'b0;
        end else if (apply) begin
          if (strobe.doSet)        flag <= 1'b1;
          else if (strobe.doClear) flag <= 1'b0;
        end
      end
      for (genvar c = 0; c < NUM_CPU; c++) begin : gFan
        assign viewFlat[c*NUM_IRQ + g] = flag;
      end
    end
  end

  // Read mux: requester's view, masked by the security filter
  always_comb begin
    rdNext = '0;
    for (int i = 0; i < 8; i++) begin
      int irq;
      int idx;
      irq = BASE_IRQ + int'(strobe.byteSel) * 8 + i;
      idx = int'(reqCpu) * NUM_IRQ + irq;
      if (irq < NUM_IRQ && idx < VIEW_W) begin
        rdNext[i] = viewFlat[idx] && !(nonSecGate && !grpBits[irq]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= strobe.doSet || strobe.doClear || strobe.doRead || strobe.doBad;
      rspErr   <= strobe.doBad;
      rspRdata <= strobe.doRead ? rdNext : 8'h00;
    end
  end

  assign activeOut = viewFlat;

endmodule

// File: rtl/irqActiveBank.sv
module irqActiveBank
  import irqActivePkg::*;
#(
  parameter int NUM_CPU  = 4,
  parameter int NUM_IRQ  = 96,
  parameter int NUM_PRIV = 32,
  parameter int BASE_IRQ = 0,
  parameter int REVISION = 2,
  parameter int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic                       reqWrite,
  input  logic [11:0]                reqAddr,
  input  logic [7:0]                 reqWdata,
  input  logic [CPU_W-1:0]           reqCpu,
  input  logic                       reqSecure,
  input  logic [NUM_IRQ-1:0]         grpBits,
  input  logic                       secExtEn,
  output logic                       rspValid,
  output logic                       rspErr,
  output logic [7:0]                 rspRdata,
  output logic [NUM_CPU*NUM_IRQ-1:0] activeOut
);

  ctrlStrobe_t strobe;

  irqActiveCtrl #(
    .NUM_IRQ (NUM_IRQ),
    .BASE_IRQ(BASE_IRQ),
    .REVISION(REVISION)
  ) uCtrl (
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqAddr (reqAddr),
    .strobe  (strobe)
  );

  irqActiveData #(
    .NUM_CPU (NUM_CPU),
    .NUM_IRQ (NUM_IRQ),
    .NUM_PRIV(NUM_PRIV),
    .BASE_IRQ(BASE_IRQ),
    .CPU_W   (CPU_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqCpu   (reqCpu),
    .reqSecure(reqSecure),
    .reqWdata (reqWdata),
    .grpBits  (grpBits),
    .secExtEn (secExtEn),
    .rspValid (rspValid),
    .rspErr   (rspErr),
    .rspRdata (rspRdata),
    .activeOut(activeOut)
  );

endmodule

// File: rtl/irqActiveBankChk.sv
module irqActiveBankChk #(
  parameter int NUM_CPU  = 4,
  parameter int NUM_IRQ  = 96,
  parameter int NUM_PRIV = 32,
  parameter int BASE_IRQ = 0,
  parameter int REVISION = 2,
  parameter int CPU_W    = 2
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       reqValid,
  input logic                       reqWrite,
  input logic [11:0]                reqAddr,
  input logic [CPU_W-1:0]           reqCpu,
  input logic                       rspValid,
  input logic                       rspErr,
  input logic [7:0]                 rspRdata,
  input logic [NUM_CPU*NUM_IRQ-1:0] activeOut
);

  localparam int PRIV_W = (NUM_PRIV < NUM_IRQ) ? NUM_PRIV : NUM_IRQ;

  logic outOfRange;
  assign outOfRange = ((32'(reqAddr[6:0]) * 32'd8) + 32'(BASE_IRQ)) >= 32'(NUM_IRQ);

  assert_rsp_follows_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  assert_rsp_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  assert_outside_window_bad_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr[11:8] != 4'h3) |=> rspErr);

  assert_err_zero_data_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rspValid && rspRdata == 8'h00));

  assert_range_bad_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr[11:8] == 4'h3 && outOfRange) |=> (rspErr && $stable(activeOut)));

  assert_revision_bad_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && REVISION != 2) |=> rspErr);

  assert_no_write_no_change_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqWrite) |=> $stable(activeOut));

  for (genvar c = 0; c < NUM_CPU; c++) begin : gIso
    assert_bank_isolation_R4: assert property (@(posedge clk) disable iff (!rstN)
      (reqValid && reqWrite && reqCpu != CPU_W'(c))
        |=> $stable(activeOut[c*NUM_IRQ +: PRIV_W]));
  end

endmodule

bind irqActiveBank irqActiveBankChk #(
  .NUM_CPU (NUM_CPU),
  .NUM_IRQ (NUM_IRQ),
  .NUM_PRIV(NUM_PRIV),
  .BASE_IRQ(BASE_IRQ),
  .REVISION(REVISION),
  .CPU_W   (CPU_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqWrite (reqWrite),
  .reqAddr  (reqAddr),
  .reqCpu   (reqCpu),
  .rspValid (rspValid),
  .rspErr   (rspErr),
  .rspRdata (rspRdata),
  .activeOut(activeOut)
);

// File: tb/tb_irqActiveBank.sv
module tb_irqActiveBank;

  localparam int NCPU  = 4;
  localparam int NIRQ  = 96;
  localparam int NPRIV = 32;
  localparam int OLD_IRQ = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic [1:0]  reqCpu = '0;
  logic reqSecure = 1'b1;
  logic [NIRQ-1:0] grpBits = '1;
  logic secExtEn = 1'b0;

  logic rspValid, rspErr;
  logic [7:0] rspRdata;
  logic [NCPU*NIRQ-1:0] activeOut;

  logic oldRspValid, oldRspErr;
  logic [7:0] oldRspRdata;
  logic [2*OLD_IRQ-1:0] oldActive;

  always #2 clk = ~clk;

  irqActiveBank #(.NUM_CPU(NCPU), .NUM_IRQ(NIRQ), .NUM_PRIV(NPRIV), .REVISION(2)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqCpu(reqCpu), .reqSecure(reqSecure), .grpBits(grpBits),
    .secExtEn(secExtEn), .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata),
    .activeOut(activeOut));

  irqActiveBank #(.NUM_CPU(2), .NUM_IRQ(OLD_IRQ), .NUM_PRIV(NPRIV), .REVISION(1)) dutOld (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqCpu(reqCpu[0]), .reqSecure(reqSecure),
    .grpBits(grpBits[OLD_IRQ-1:0]), .secExtEn(secExtEn), .rspValid(oldRspValid),
    .rspErr(oldRspErr), .rspRdata(oldRspRdata), .activeOut(oldActive));

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] rdata;
    logic       err;
    int         due;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  logic model [NCPU][NIRQ];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endfunction

  function automatic bit visible(int irq, bit sec);
    return !(secExtEn && !sec && !grpBits[irq]);
  endfunction

  // Driver: computes expectation from the requirements, pushes it, drives the bus
  task automatic access(bit wr, logic [11:0] addr, logic [7:0] data, int cpu, bit sec, string tag);
    expItem_t it;
    int first;
    bit bad;
    first = int'(addr[6:0]) * 8;
    bad = (addr < 12'h300) || (addr > 12'h3FF) || (first >= NIRQ);
    it.rdata = 8'h00;
    it.err = bad;
    it.due = cyc + 1;
    it.tag = tag;
    if (!bad) begin
      for (int i = 0; i < 8; i++) begin
        int irq;
        irq = first + i;
        if (!wr) begin
          it.rdata[i] = model[cpu][irq] && visible(irq, sec);
        end else if (data[i] && visible(irq, sec)) begin
          if (irq < NPRIV) model[cpu][irq] = !addr[7];
          else for (int c = 0; c < NCPU; c++) model[c][irq] = !addr[7];
        end
      end
    end
    expQ.push_back(it);
    reqValid  = 1'b1;
    reqWrite  = wr;
    reqAddr   = addr;
    reqWdata  = data;
    reqCpu    = 2'(cpu);
    reqSecure = sec;
    @(negedge clk);
    reqValid  = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic stateCheck(string tag);
    int bad;
    drain();
    bad = 0;
    for (int c = 0; c < NCPU; c++)
      for (int n = 0; n < NIRQ; n++)
        if (activeOut[c*NIRQ + n] !== model[c][n]) bad++;
    check(bad == 0, tag, "activeOut mismatching bits", 64'(bad), 64'd0);
  endtask

  // Monitor: pops expectations as responses appear
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (expQ.size() > 0 && expQ[0].due == cyc) begin
          expItem_t it;
          it = expQ.pop_front();
          check(rspValid === 1'b1, it.tag, "rspValid", 64'(rspValid), 64'd1);
          check(rspErr === it.err, it.tag, "rspErr", 64'(rspErr), 64'(it.err));
          check(rspRdata === it.rdata, it.tag, "rspRdata", 64'(rspRdata), 64'(it.rdata));
        end else if (rspValid !== 1'b0) begin
          check(1'b0, "R10", "unexpected rspValid", 64'(rspValid), 64'd0);
        end
        if (oldRspValid === 1'b1)
          check(oldRspErr === 1'b1 && oldRspRdata === 8'h00, "R9",
                "old revision err/data", {55'd0, oldRspErr, oldRspRdata}, 64'h100);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCPU; c++) for (int n = 0; n < NIRQ; n++) model[c][n] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(activeOut === '0, "R1", "activeOut after reset", 64'(activeOut[63:0]), 64'd0);
    check(rspValid === 1'b0 && rspErr === 1'b0, "R1", "rsp after reset",
          {62'd0, rspValid, rspErr}, 64'd0);

    // R2 / R4 banked private set
    access(1, 12'h300, 8'hA5, 1, 1, "R2_R4 set priv cpu1");
    access(0, 12'h300, 8'h00, 1, 1, "R4 read cpu1");
    access(0, 12'h300, 8'h00, 0, 1, "R4 read cpu0");
    access(0, 12'h380, 8'h00, 1, 1, "R11 read via clear window");
    access(1, 12'h300, 8'h00, 1, 1, "R2 write zero");
    stateCheck("R4");
    // R4/R5 boundary between banked 31 and shared 32
    access(1, 12'h303, 8'h80, 2, 1, "R4 irq31 cpu2");
    access(1, 12'h304, 8'h01, 3, 1, "R5 irq32 cpu3");
    access(0, 12'h304, 8'h00, 0, 1, "R5 read irq32 cpu0");
    access(0, 12'h303, 8'h00, 0, 1, "R4 read irq31 cpu0");
    stateCheck("R5");
    // R5 shared, R3 clear
    access(1, 12'h308, 8'hFF, 2, 1, "R5 set shared");
    access(1, 12'h388, 8'h0F, 0, 1, "R3 clear shared");
    access(1, 12'h388, 8'h00, 0, 1, "R3 clear zero");
    access(0, 12'h388, 8'h00, 3, 1, "R11 read cpu3");
    access(1, 12'h380, 8'h21, 1, 1, "R3 clear priv cpu1");
    access(0, 12'h300, 8'h00, 1, 1, "R3 read cpu1");
    stateCheck("R3");
    // R11 idle does not change state
    repeat (5) @(negedge clk);
    stateCheck("R11");
    // R8 boundary bytes
    access(1, 12'h30B, 8'h80, 0, 1, "R8 last valid byte set");
    access(1, 12'h30C, 8'hFF, 0, 1, "R8 set out of range");
    access(0, 12'h30C, 8'h00, 0, 1, "R8 read out of range");
    access(1, 12'h38C, 8'hFF, 0, 1, "R8 clear out of range");
    access(0, 12'h38B, 8'h00, 2, 1, "R8 last valid read");
    access(1, 12'h38B, 8'h80, 0, 1, "R8 last valid clear");
    stateCheck("R8");
    // R10 outside window
    access(1, 12'h2FF, 8'hFF, 0, 1, "R10 below window");
    access(0, 12'h400, 8'h00, 0, 1, "R10 above window");
    stateCheck("R10");
    // R6 / R7 security filter
    secExtEn = 1'b1;
    grpBits[47:40] = 8'h3C;
    grpBits[7:0]   = 8'h0F;
    access(1, 12'h305, 8'hFF, 0, 0, "R6 nonsecure set shared");
    access(1, 12'h300, 8'hFF, 3, 0, "R6 nonsecure set priv");
    access(0, 12'h305, 8'h00, 1, 0, "R7 nonsecure read");
    access(0, 12'h305, 8'h00, 1, 1, "R7 secure read");
    access(1, 12'h305, 8'hFF, 2, 1, "R6 secure set");
    access(0, 12'h385, 8'h00, 2, 0, "R7 nonsecure read clear window");
    access(1, 12'h385, 8'hFF, 0, 0, "R6 nonsecure clear");
    access(0, 12'h305, 8'h00, 0, 1, "R6 secure read back");
    stateCheck("R6");
    secExtEn = 1'b0;
    access(0, 12'h305, 8'h00, 0, 0, "R6 ext off read");
    stateCheck("R7");
    check(oldActive === '0, "R9", "old revision state", 64'(oldActive[63:0]), 64'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule